// File: doc/BRIEF.md
# Quadrature Period Counter With Turn Split

This block follows a sine/cosine position sensor at the granularity of a quarter signal period. The signs of the two channels form a two-bit Gray-coded quadrant. Every legal move to a neighbouring quadrant moves a 37-bit wrap-around period counter up or down by one. A move across two quadrants in one sample cannot be resolved. It raises a sticky sync error and leaves the count unchanged.

The counter value is joined with the sub-quadrant part of the fine interpolation word to form one wide position word. A two-bit scale setting discards a number of low bits from that word. The result is cut at a programmable boundary into a singleturn field and a multiturn field, and each field receives its own offset modulo its own width. A direction option reverses the counting sense and mirrors the fine bits. An absolute value, such as one received over a serial absolute-data link at power-up or on request, can be loaded into the counter. The two fields are captured into output registers only on a latch request, so that software reads a consistent snapshot.

Top module: `period_turn_tracker`

## Requirements
- R1: With `dir_inv` low, a quadrant move of +1 in the index order 0,1,2,3 (Gray codes {sin_neg,cos_neg} = 00,01,11,10) raises the counter by one, modulo 2^37, one clock after the move is seen.
- R2: With `dir_inv` low, a move of -1 lowers the counter by one, so that a decrement from 0 wraps to 2^37-1.
- R3: A move of two quadrants leaves the counter unchanged and sets `sync_err`, which then stays set until a preset.
- R4: `preset_load` copies `preset_val` into the counter and clears `sync_err`, and it wins over a quadrant move in the same cycle.
- R5: With `dir_inv` high, a +1 move lowers the counter, a -1 move raises it, and the 11 fine bits are used bit-inverted.
- R6: The position word is counter*2^11 + fine bits, shifted right by 0, 3, 6 or 11 bits for `res_sel` = 0, 1, 2 or 3.
- R7: `st_pos` holds the low S bits of the position word plus `st_off`, modulo 2^S, where S = min(`st_res`, 26). Bits of `st_pos` at and above S are zero.
- R8: `mt_pos` holds the M position bits that start at bit S, plus `mt_off`, modulo 2^M, where M = min(3*(`mt_res`+1), 24).
- R9: `st_pos` and `mt_pos` are loaded only on the clock edge at which `latch_req` is high, and they hold their value otherwise.
- R10: After reset the counter, both output fields and `sync_err` are zero. The first quadrant sampled after reset is taken as the reference and is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sin_neg | input | 1 | Sine channel below its midpoint |
| cos_neg | input | 1 | Cosine channel below its midpoint |
| fine_frac | input | 11 | Sub-quadrant bits of the 13-bit fine interpolation word |
| dir_inv | input | 1 | Reverse the counting sense and mirror the fine bits |
| preset_load | input | 1 | Load the absolute value into the counter |
| preset_val | input | 37 | Absolute counter value |
| res_sel | input | 2 | Position scaling (number of discarded low bits) |
| st_res | input | 5 | Singleturn field width |
| mt_res | input | 3 | Multiturn field width code |
| st_off | input | 26 | Singleturn offset |
| mt_off | input | 24 | Multiturn offset |
| latch_req | input | 1 | Capture both fields into the outputs |
| st_pos | output | 26 | Latched singleturn position |
| mt_pos | output | 24 | Latched multiturn position |
| sync_err | output | 1 | Sticky flag for an unresolvable quadrant jump |

## Verification
A wrong quadrant reference or a wrong counter value shows up in the next latched `st_pos` as a count that is off by whole steps. Since the bench latches after every scenario, the fault is reported at most a few cycles after the stimulus that caused it. The field arithmetic is checked for every scale code and at the field-width clamps. Offset wrap and counter wrap across zero are checked at the outputs, because a carry or borrow that leaks into the wrong field changes `mt_pos` at once. A missed or spurious sync error is visible directly on `sync_err` one cycle after the jump or the preset.

// File: rtl/period_turn_pkg.sv
package period_turn_pkg;

  typedef enum logic [1:0] {
    MOVE_NONE = 2'd0,
    MOVE_FWD  = 2'd1,
    MOVE_BWD  = 2'd2,
    MOVE_JUMP = 2'd3
  } move_e;

  // Gray quadrant {sin_neg,cos_neg} to a linear index: 00->0, 01->1, 11->2, 10->3
  function automatic logic [1:0] quad_index(input logic [1:0] gray);
    return {gray[1], gray[1] ^ gray[0]};
  endfunction

  function automatic move_e classify_move(input logic [1:0] ref_idx,
                                          input logic [1:0] cur_idx);
    logic [1:0] delta;
    delta = cur_idx - ref_idx;
    case (delta)
      2'd1:    return MOVE_FWD;
      2'd3:    return MOVE_BWD;
      2'd2:    return MOVE_JUMP;
      default: return MOVE_NONE;
    endcase
  endfunction

endpackage

// File: rtl/quad_tracker.sv
module quad_tracker
  import period_turn_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  sin_neg,
  input  logic  cos_neg,
  output move_e move
);

  logic [1:0] cur_idx;
  logic [1:0] ref_idx;
  logic       primed;

  assign cur_idx = quad_index({sin_neg, cos_neg});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_idx <= 2'd0;
      primed  <= 1'b0;
    end else begin
      ref_idx <= cur_idx;
      primed  <= 1'b1;
    end
  end

  // the first sample after reset only sets the reference
  assign move = primed ? classify_move(ref_idx, cur_idx) : MOVE_NONE;

endmodule

// File: rtl/period_counter.sv
module period_counter
  import period_turn_pkg::*;
#(
  parameter int CNT_W = 37
) (
  input  logic             clk,
  input  logic             rst_n,
  input  move_e            move,
  input  logic             dir_inv,
  input  logic             preset_load,
  input  logic [CNT_W-1:0] preset_val,
  output logic [CNT_W-1:0] count,
  output logic             sync_err
);

  logic step_up;
  logic step_dn;
  logic jump_ev;

  assign step_up = (move == MOVE_FWD && !dir_inv) || (move == MOVE_BWD && dir_inv);
  assign step_dn = (move == MOVE_BWD && !dir_inv) || (move == MOVE_FWD && dir_inv);
  assign jump_ev = (move == MOVE_JUMP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (preset_load) begin
      count <= preset_val;
    end else if (step_up) begin
      count <= count + CNT_W'(1);
    end else if (step_dn) begin
      count <= count - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_err <= 1'b0;
    end else if (preset_load) begin
      sync_err <= 1'b0;
    end else if (jump_ev) begin
      sync_err <= 1'b1;
    end
  end

endmodule

// File: rtl/turn_split.sv
module turn_split #(
  parameter int CNT_W  = 37,
  parameter int FRAC_W = 11,
  parameter int ST_W   = 26,
  parameter int MT_W   = 24,
  parameter int SCALE_STEP = 3
) (
  input  logic [CNT_W-1:0]  count,
  input  logic [FRAC_W-1:0] fine_frac,
  input  logic              dir_inv,
  input  logic [1:0]        res_sel,
  input  logic [4:0]        st_res,
  input  logic [2:0]        mt_res,
  input  logic [ST_W-1:0]   st_off,
  input  logic [MT_W-1:0]   mt_off,
  output logic [ST_W-1:0]   st_field,
  output logic [MT_W-1:0]   mt_field
);

  localparam int POS_W = CNT_W + FRAC_W;

  function automatic int drop_bits(input logic [1:0] sel);
    return (sel == 2'd3) ? FRAC_W : SCALE_STEP * int'(sel);
  endfunction

  function automatic int st_width(input logic [4:0] code);
    return (int'(code) > ST_W) ? ST_W : int'(code);
  endfunction

  function automatic int mt_width(input logic [2:0] code);
    int w;
    w = 3 * (int'(code) + 1);
    return (w > MT_W) ? MT_W : w;
  endfunction

  function automatic logic [POS_W-1:0] low_mask(input int n);
    return ~({POS_W{1'b1}} << n);
  endfunction

  logic [FRAC_W-1:0] frac_used;
  logic [POS_W-1:0]  pos_word;
  logic [POS_W-1:0]  st_sum;
  logic [POS_W-1:0]  mt_sum;
  int                st_n;
  int                mt_n;

  assign frac_used = fine_frac ^ {FRAC_W{dir_inv}};

  always_comb begin
    st_n     = st_width(st_res);
    mt_n     = mt_width(mt_res);
    pos_word = {count, frac_used} >> drop_bits(res_sel);
    st_sum   = ((pos_word & low_mask(st_n)) + POS_W'(st_off)) & low_mask(st_n);
    mt_sum   = (((pos_word >> st_n) & low_mask(mt_n)) + POS_W'(mt_off)) & low_mask(mt_n);
    st_field = st_sum[ST_W-1:0];
    mt_field = mt_sum[MT_W-1:0];
  end

endmodule

// File: rtl/period_turn_tracker.sv
module period_turn_tracker
  import period_turn_pkg::*;
#(
  parameter int CNT_W  = 37,
  parameter int FRAC_W = 11,
  parameter int ST_W   = 26,
  parameter int MT_W   = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sin_neg,
  input  logic              cos_neg,
  input  logic [FRAC_W-1:0] fine_frac,
  input  logic              dir_inv,
  input  logic              preset_load,
  input  logic [CNT_W-1:0]  preset_val,
  input  logic [1:0]        res_sel,
  input  logic [4:0]        st_res,
  input  logic [2:0]        mt_res,
  input  logic [ST_W-1:0]   st_off,
  input  logic [MT_W-1:0]   mt_off,
  input  logic              latch_req,
  output logic [ST_W-1:0]   st_pos,
  output logic [MT_W-1:0]   mt_pos,
  output logic              sync_err
);

  move_e            move_w;
  logic [CNT_W-1:0] count_w;
  logic [ST_W-1:0]  st_field_w;
  logic [MT_W-1:0]  mt_field_w;

  quad_tracker u_quad (
    .clk     (clk),
    .rst_n   (rst_n),
    .sin_neg (sin_neg),
    .cos_neg (cos_neg),
    .move    (move_w)
  );

  period_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk         (clk),
    .rst_n       (rst_n),
    .move        (move_w),
    .dir_inv     (dir_inv),
    .preset_load (preset_load),
    .preset_val  (preset_val),
    .count       (count_w),
    .sync_err    (sync_err)
  );

  turn_split #(.CNT_W(CNT_W), .FRAC_W(FRAC_W), .ST_W(ST_W), .MT_W(MT_W)) u_split (
    .count     (count_w),
    .fine_frac (fine_frac),
    .dir_inv   (dir_inv),
    .res_sel   (res_sel),
    .st_res    (st_res),
    .mt_res    (mt_res),
    .st_off    (st_off),
    .mt_off    (mt_off),
    .st_field  (st_field_w),
    .mt_field  (mt_field_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_pos <= '0;
      mt_pos <= '0;
    end else if (latch_req) begin
      st_pos <= st_field_w;
      mt_pos <= mt_field_w;
    end
  end

endmodule

// File: rtl/period_turn_tracker_chk.sv
module period_turn_tracker_chk #(
  parameter int CNT_W = 37,
  parameter int ST_W  = 26,
  parameter int MT_W  = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       move,
  input logic [CNT_W-1:0] count,
  input logic             sync_err,
  input logic             dir_inv,
  input logic             preset_load,
  input logic [CNT_W-1:0] preset_val,
  input logic             latch_req,
  input logic [ST_W-1:0]  st_pos,
  input logic [MT_W-1:0]  mt_pos
);

  // move codes: 1 forward, 2 backward, 3 jump
  assert_fwd_count_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (move == 2'd1 && !dir_inv && !preset_load) |=> count == $past(count) + CNT_W'(1));

  assert_bwd_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (move == 2'd2 && !dir_inv && !preset_load) |=> count == $past(count) - CNT_W'(1));

  assert_jump_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (move == 2'd3 && !preset_load) |=> (count == $past(count)) && sync_err);

  assert_err_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_err && !preset_load) |=> sync_err);

  assert_preset_R4: assert property (@(posedge clk) disable iff (!rst_n)
    preset_load |=> (count == $past(preset_val)) && !sync_err);

  assert_inv_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (move == 2'd1 && dir_inv && !preset_load) |=> count == $past(count) - CNT_W'(1));

  assert_hold_outputs_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_req |=> $stable(st_pos) && $stable(mt_pos));

endmodule

bind period_turn_tracker period_turn_tracker_chk #(
  .CNT_W(CNT_W), .ST_W(ST_W), .MT_W(MT_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .move        (move_w),
  .count       (count_w),
  .sync_err    (sync_err),
  .dir_inv     (dir_inv),
  .preset_load (preset_load),
  .preset_val  (preset_val),
  .latch_req   (latch_req),
  .st_pos      (st_pos),
  .mt_pos      (mt_pos)
);

// File: tb/test_period_turn_tracker.sv
`timescale 1ns/1ps
module test_period_turn_tracker;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sin_neg = 1'b0;
  logic        cos_neg = 1'b0;
  logic [10:0] fine_frac = '0;
  logic        dir_inv = 1'b0;
  logic        preset_load = 1'b0;
  logic [36:0] preset_val = '0;
  logic [1:0]  res_sel = 2'd3;
  logic [4:0]  st_res = 5'd8;
  logic [2:0]  mt_res = 3'd0;
  logic [25:0] st_off = '0;
  logic [23:0] mt_off = '0;
  logic        latch_req = 1'b0;
  logic [25:0] st_pos;
  logic [23:0] mt_pos;
  logic        sync_err;

  int n_checks = 0;
  int n_fail = 0;
  int cur_q = 0;
  longint unsigned exp_cnt = 0;
  localparam longint unsigned CNT_MOD = 64'd1 << 37;

  always #2.5 clk = ~clk;

  period_turn_tracker i_period_turn_tracker (
    .clk(clk), .rst_n(rst_n), .sin_neg(sin_neg), .cos_neg(cos_neg),
    .fine_frac(fine_frac), .dir_inv(dir_inv), .preset_load(preset_load),
    .preset_val(preset_val), .res_sel(res_sel), .st_res(st_res), .mt_res(mt_res),
    .st_off(st_off), .mt_off(mt_off), .latch_req(latch_req),
    .st_pos(st_pos), .mt_pos(mt_pos), .sync_err(sync_err)
  );

  task automatic check(input string req, input longint unsigned act, input longint unsigned exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // quadrant index to Gray code: 0->00, 1->01, 2->11, 3->10
  task automatic drive_quad(input int q);
    case (q & 3)
      0: {sin_neg, cos_neg} = 2'b00;
      1: {sin_neg, cos_neg} = 2'b01;
      2: {sin_neg, cos_neg} = 2'b11;
      default: {sin_neg, cos_neg} = 2'b10;
    endcase
  endtask

  task automatic move_by(input int dq);
    cur_q = (cur_q + dq + 4) % 4;
    drive_quad(cur_q);
    @(negedge clk);
  endtask

  task automatic model_step(input int dir_sign);
    if (dir_sign > 0) exp_cnt = (exp_cnt + 1) % CNT_MOD;
    else exp_cnt = (exp_cnt + CNT_MOD - 1) % CNT_MOD;
  endtask

  task automatic do_latch();
    latch_req = 1'b1;
    @(negedge clk);
    latch_req = 1'b0;
  endtask

  // expected fields, computed with arithmetic rather than masks and shifts
  task automatic expect_fields(output longint unsigned e_st, output longint unsigned e_mt);
    longint unsigned frac, pos, st_mod, mt_mod, hi;
    int drop, sn, mn;
    frac = dir_inv ? (longint'(2047) - fine_frac) : longint'(fine_frac);
    pos = exp_cnt * 2048 + frac;
    drop = (res_sel == 3) ? 11 : 3 * res_sel;
    pos = pos / (64'd1 << drop);
    sn = (st_res > 26) ? 26 : st_res;
    mn = 3 * (mt_res + 1);
    if (mn > 24) mn = 24;
    st_mod = 64'd1 << sn;
    mt_mod = 64'd1 << mn;
    hi = pos / st_mod;
    e_st = ((pos % st_mod) + st_off) % st_mod;
    e_mt = ((hi % mt_mod) + mt_off) % mt_mod;
  endtask

  task automatic latch_and_check(input string st_req, input string mt_req);
    longint unsigned e_st, e_mt;
    do_latch();
    expect_fields(e_st, e_mt);
    check(st_req, st_pos, e_st);
    check(mt_req, mt_pos, e_mt);
  endtask

  task automatic t_reset();
    // R10: quadrant 3 held through reset becomes the reference, not a count
    cur_q = 3;
    drive_quad(3);
    repeat (3) @(negedge clk);
    check("R10 st_pos at reset", st_pos, 0);
    check("R10 mt_pos at reset", mt_pos, 0);
    check("R10 sync_err at reset", sync_err, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R10 no count on first sample", sync_err, 0);
    latch_and_check("R10 counter zero st", "R10 counter zero mt");
  endtask

  task automatic t_forward();
    for (int i = 0; i < 5; i++) begin move_by(1); model_step(1); end
    latch_and_check("R1 forward st", "R1 forward mt");
    check("R1 forward value", st_pos, 5);
  endtask

  task automatic t_backward();
    for (int i = 0; i < 7; i++) begin move_by(-1); model_step(-1); end
    latch_and_check("R2 wrap st", "R2 wrap mt");
    check("R2 wrap value st", st_pos, 254);
    check("R2 wrap value mt", mt_pos, 7);
  endtask

  task automatic t_jump();
    move_by(2);
    check("R3 flag set", sync_err, 1);
    latch_and_check("R3 no count st", "R3 no count mt");
    move_by(1); model_step(1);
    check("R3 flag sticky", sync_err, 1);
    latch_and_check("R3 count after jump st", "R3 count after jump mt");
  endtask

  task automatic t_preset();
    preset_val = 37'h1234;
    preset_load = 1'b1;
    cur_q = (cur_q + 1) % 4;
    drive_quad(cur_q);
    @(negedge clk);
    preset_load = 1'b0;
    exp_cnt = 64'h1234;
    check("R4 flag cleared", sync_err, 0);
    latch_and_check("R4 preset st", "R4 preset mt");
    check("R4 preset st value", st_pos, 64'h34);
    check("R4 preset mt value", mt_pos, 2);
  endtask

  task automatic t_direction();
    dir_inv = 1'b1;
    for (int i = 0; i < 3; i++) begin move_by(1); model_step(-1); end
    move_by(-1); model_step(1);
    res_sel = 2'd0;
    st_res = 5'd16;
    fine_frac = 11'h005;
    latch_and_check("R5 inverted st", "R5 inverted mt");
    check("R5 inverted st value", st_pos, ((64'h1232 * 2048) + 64'h7FA) % 65536);
    dir_inv = 1'b0;
  endtask

  task automatic t_scale();
    fine_frac = 11'h2BC;
    st_res = 5'd20;
    mt_res = 3'd2;
    for (int r = 0; r < 4; r++) begin
      res_sel = r[1:0];
      latch_and_check("R6 scaled st", "R8 scaled mt");
    end
  endtask

  task automatic t_offsets();
    res_sel = 2'd3;
    st_res = 5'd8;
    mt_res = 3'd1;
    st_off = 26'h1F0;
    mt_off = 24'hFFFFFF;
    latch_and_check("R7 offset wrap st", "R8 offset wrap mt");
    st_off = '0;
    mt_off = 24'h3;
    for (int i = 0; i < 2; i++) begin move_by(-1); model_step(-1); end
    latch_and_check("R7 offset st", "R8 offset mt");
  endtask

  task automatic t_clamp();
    preset_val = 37'h1F_2345_6789;
    preset_load = 1'b1;
    @(negedge clk);
    preset_load = 1'b0;
    exp_cnt = 64'h1F_2345_6789;
    st_res = 5'd31;
    mt_res = 3'd7;
    st_off = 26'h3FF_FFFF;
    mt_off = 24'h00_0010;
    latch_and_check("R7 clamp st", "R8 clamp mt");
    st_res = 5'd4;
    st_off = '0;
    latch_and_check("R7 narrow st", "R8 narrow mt");
    check("R7 upper bits zero", st_pos >> 4, 0);
  endtask

  task automatic t_hold();
    longint unsigned held_st, held_mt;
    held_st = st_pos;
    held_mt = mt_pos;
    for (int i = 0; i < 3; i++) begin move_by(1); model_step(1); end
    st_off = 26'h5;
    @(negedge clk);
    check("R9 st held", st_pos, held_st);
    check("R9 mt held", mt_pos, held_mt);
    latch_and_check("R9 updated st", "R9 updated mt");
  endtask

  initial begin
    t_reset();
    t_forward();
    t_backward();
    t_jump();
    t_preset();
    t_direction();
    t_scale();
    t_offsets();
    t_clamp();
    t_hold();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    #100000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

endmodule